// File: doc/BRIEF.md
# Nth-Chance Clock Replacement Engine

This engine chooses a frame to evict from a fixed ring of frames. Each frame carries a reference bit and a small count of the sweeps in which it was found unreferenced. An access port marks frames as recently used. A victim request starts a search. The clock hand advances one frame per cycle. Referenced frames lose their bit. Unreferenced frames age. The search stops at the first frame whose age reaches the run-time threshold N.

The threshold sets how many unreferenced passes a frame survives. With N=1 the engine behaves as plain second-chance replacement. Larger N keeps a frame resident for more sweeps. The chosen index comes back with a one-cycle completion pulse. The hand then rests on that frame, so the next search starts just after it.

Top module: `nchance_clock`

## Requirements
- R1: After reset, `done` and `busy` are 0, every reference bit and age count is 0, and the hand rests on frame FRAMES-1, so the first search inspects frame 0 first.
- R2: A search inspects exactly one frame per clock cycle. The hand first moves to the next frame, wrapping from FRAMES-1 to 0, and then inspects that frame. `busy` stays 1 until the search ends.
- R3: An inspected frame whose reference bit is 1 has the bit cleared and its age reset to 0, and the search continues.
- R4: An inspected frame whose reference bit is 0 has its age incremented, saturating at 2^CNT_W-1. It is chosen as victim when the new age is at least `thresh`; otherwise the search continues.
- R5: `acc_valid` with `acc_frame` sets that frame's reference bit at the clock edge. If the hand clears the same bit on the same edge, the set wins.
- R6: When a victim is chosen, `done` is 1 for exactly one cycle with `victim` holding its index. On that same edge `busy` falls, the victim's reference bit and age return to 0, and the hand stays on the victim.
- R7: `req` is accepted only while `busy` is 0. A request raised during a search has no effect.
- R8: With `thresh`=1 and every frame referenced, a search clears the whole ring and evicts the frame it inspected first, after FRAMES+1 inspections.
- R9: `thresh` is read on every inspection. A value of 0 acts like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A frame was accessed this cycle |
| acc_frame | input | IDX_W | Index of the accessed frame |
| thresh | input | CNT_W | Age threshold N for eviction |
| req | input | 1 | Start a victim search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: victim valid |
| victim | output | IDX_W | Index of the chosen frame |

## Verification
The bench builds the engine with FRAMES=4 and CNT_W=2. This size makes it practical to sweep every threshold from 0 to the saturating value 3 against all 16 reference-bit patterns. Because the ring is small, each sweep wraps several times, so the wrap point, counter saturation and repeated aging across consecutive searches are all exercised. The random accesses injected during a search often land on the frame being inspected, which tests the collision between setting and clearing a reference bit.

// File: rtl/nchance_clock.sv
module nchance_clock #(
  parameter int FRAMES = 8,
  parameter int CNT_W = 3,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic [CNT_W-1:0] thresh,
  input  logic             req,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [FRAMES-1:0] ref_q;
  logic [CNT_W-1:0]  age_q [FRAMES];
  logic [IDX_W-1:0]  hand_q;
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  victim_q;

  wire [IDX_W-1:0] probe   = (hand_q == LAST) ? '0 : hand_q + 1'b1;
  wire [CNT_W-1:0] age_now = age_q[probe];
  wire [CNT_W-1:0] age_inc = (age_now == '1) ? age_now : age_now + 1'b1;
  wire             hit     = busy_q && !ref_q[probe] && (age_inc >= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q    <= '0;
      hand_q   <= LAST;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      victim_q <= '0;
      for (int i = 0; i < FRAMES; i++) age_q[i] <= '0;
    end else begin
      done_q <= hit;
      if (busy_q) begin
        hand_q       <= probe;
        ref_q[probe] <= 1'b0;
        if (ref_q[probe] || hit) age_q[probe] <= '0;
        else                     age_q[probe] <= age_inc;
        if (hit) begin
          busy_q   <= 1'b0;
          victim_q <= probe;
        end
      end else if (req) begin
        busy_q <= 1'b1;
      end
      if (acc_valid && (int'(acc_frame) < FRAMES)) ref_q[acc_frame] <= 1'b1;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign victim = victim_q;

endmodule

// File: rtl/nchance_clock_chk.sv
module nchance_clock_chk #(
  parameter int FRAMES = 8,
  parameter int IDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [IDX_W-1:0]  acc_frame,
  input logic              busy,
  input logic              done,
  input logic [FRAMES-1:0] ref_q
);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_done_after_search_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  assert_access_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (int'(acc_frame) < FRAMES)) |=> ref_q[$past(acc_frame)]);

endmodule

bind nchance_clock nchance_clock_chk #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
  .busy(busy), .done(done), .ref_q(ref_q)
);

// File: tb/sim_nchance_clock.sv
module sim_nchance_clock;
  localparam int CLK_PERIOD = 10;
  localparam int F = 4;
  localparam int CW = 2;
  localparam int IW = 2;
  localparam int CMAX = 3;

  logic clk = 0, rst_n = 0, acc_valid = 0, req = 0;
  logic [IW-1:0] acc_frame = '0;
  logic [CW-1:0] thresh = 2'd1;
  logic busy, done;
  logic [IW-1:0] victim;

  int checks = 0, fails = 0;
  int mref[F], mcnt[F], mhand, mbusy, mdone, mvic, lat;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  nchance_clock #(.FRAMES(F), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .thresh(thresh), .req(req), .busy(busy), .done(done), .victim(victim));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < F; i++) begin mref[i] = 0; mcnt[i] = 0; end
    mhand = F - 1; mbusy = 0; mdone = 0; mvic = 0;
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit av, input int af, input bit rq);
    int p, c, n;
    acc_valid = av; acc_frame = IW'(af); req = rq;
    @(posedge clk);
    n = (int'(thresh) == 0) ? 0 : int'(thresh);
    mdone = 0;
    if (mbusy != 0) begin
      p = (mhand + 1) % F;
      mhand = p;
      lat++;
      if (mref[p] != 0) begin
        mref[p] = 0; mcnt[p] = 0;
      end else begin
        c = mcnt[p] + 1;
        if (c > CMAX) c = CMAX;
        if (c >= n) begin
          mdone = 1; mvic = p; mref[p] = 0; mcnt[p] = 0; mbusy = 0;
        end else mcnt[p] = c;
      end
    end else if (rq) begin
      mbusy = 1; lat = 0;
    end
    if (av) mref[af] = 1;
    @(negedge clk);
    chk("R2 busy", int'(busy), mbusy);
    chk("R6 done", int'(done), mdone);
    if (mdone != 0) chk("R4 victim", int'(victim), mvic);
  endtask

  task automatic search(input bit noisy, input bit hold_req);
    int guard = 0;
    step(0, 0, 1);
    while (mbusy != 0 && guard < 40) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(noisy && lfsr[0], int'(lfsr[2:1]), hold_req);
      guard++;
    end
    step(0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    rst_n = 1;

    // R8: all referenced, N=1, round robin from frame 0
    thresh = 2'd1;
    for (int i = 0; i < F; i++) step(1, i, 0);
    step(0, 0, 1);
    while (mbusy != 0) step(0, 0, 0);
    chk("R8 victim", int'(victim), 0);
    chk("R8 inspections", lat, F + 1);
    step(0, 0, 0);
    chk("R6 done one cycle", int'(done), 0);

    // R5: access lands on the frame being cleared; set must win
    for (int i = 0; i < F; i++) step(1, i, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    step(1, 2, 0);
    while (mbusy != 0) step(0, 0, 0);
    chk("R3 sweep victim", int'(victim), 1);
    search(0, 0);
    chk("R5 set wins victim", int'(victim), 3);

    // R7: req held high for the whole search
    search(0, 1);
    chk("R7 no restart", int'(busy), 0);

    // R4 R9: sweep thresholds 0..3 against every reference pattern
    for (int n = 0; n < 4; n++) begin
      thresh = CW'(n);
      for (int pat = 0; pat < 16; pat++) begin
        for (int i = 0; i < F; i++) if (pat[i]) step(1, i, 0);
        search(pat[0], 0);
      end
    end

    // R9: threshold 0 behaves as 1 from a clean referenced ring
    rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
    thresh = 2'd0;
    step(1, 0, 0);
    search(0, 0);
    chk("R9 zero threshold victim", int'(victim), 1);
    chk("R9 zero threshold inspections", lat, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule